// File: doc/BRIEF.md
# Software Transfer Activation Register

This block is a single 8-bit control register through which software launches a transfer on a data-transfer engine and picks the vector that engine should use. The top bit is an activation enable flag. The lower seven bits are a vector number. The register turns the vector number into a 16-bit vector-table address. When software sets the enable flag, the register sends a one-cycle start request to the engine.

The engine reports four status lines: a transfer is in progress, one transfer has just finished, the transfer count is exhausted, and its chain/interrupt selection. From these the register decides what happens to the enable flag after a transfer. In the normal case the flag clears by itself. Otherwise it stays set and the register raises a completion interrupt to the CPU. The CPU then acknowledges by writing 0 to the flag.

While the flag is set, the vector field is locked against writes. A standby input clears the register in the same way as reset.

Top module: `swact_act_reg`

## Requirements
- R1: Bit 7 of the register is the enable flag and bits 6..0 are the vector number. Asserting `bus_rd` for one cycle makes `bus_rdata` present the pre-edge contents from the following cycle on, and it holds until the next read. A read changes no state.
- R2: Reset and `hw_standby` each force the register to 0x00. They also drop `done_irq` and `act_req`.
- R3: A write loads bits 6..0 into the vector only if the enable flag was 0 before that write. Otherwise the vector keeps its value.
- R4: `vec_addr` always equals 0x0400 plus twice the vector number. For example, vector 0x10 gives 0x0420.
- R5: A write with bit 7 = 1 while the flag is 0 sets the flag. It also drives `act_req` high for exactly the one cycle after the write.
- R6: When `eng_done` pulses with the flag at 1, `eng_chain_sel` = 0 and `eng_cnt_zero` = 0, the flag is 0 in the next cycle and `done_irq` stays 0.
- R7: When `eng_done` pulses with the flag at 1 and either `eng_chain_sel` = 1 or `eng_cnt_zero` = 1, the flag stays 1. `done_irq` is 1 from the next cycle on.
- R8: While the flag is 1 and no completion interrupt is pending, the flag holds across `eng_busy` and across CPU writes of bit 7 = 0, until an `eng_done` pulse arrives.
- R9: A CPU write with bit 7 = 0 while `done_irq` is 1 and `eng_busy` is 0 clears both the flag and `done_irq` in the next cycle. With `eng_busy` = 1 the same write is ignored.
- R10: If a CPU write lands in the same cycle as an `eng_done` pulse that finds the flag at 1, the hardware outcome of R6 or R7 decides the flag. The vector stays locked.
- R11: An `eng_done` pulse while the flag is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_standby | input | 1 | Standby: clears the register like reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data: bit 7 enable, bits 6..0 vector |
| bus_rdata | output | 8 | Read data, registered on `bus_rd` |
| eng_busy | input | 1 | Software-started transfer in progress |
| eng_done | input | 1 | One-cycle pulse: a transfer ended |
| eng_cnt_zero | input | 1 | Programmed transfer count exhausted |
| eng_chain_sel | input | 1 | Chain/interrupt-select setting of the engine |
| act_req | output | 1 | One-cycle activation request to the engine |
| vec_addr | output | 16 | Vector-table address derived from the vector |
| done_irq | output | 1 | Completion interrupt request to the CPU |

## Verification
On every clock, the assertions check several rules. The vector stays frozen while the flag is set. The address stays even. `act_req` lasts one cycle and only with the flag set. The flag's next state follows each kind of end-of-transfer pulse. Standby clears everything, and an interrupt never exists without the flag.

Some behaviours only the bench's scenarios can show: the readback timing of `bus_rdata`, the exact address values, and which way a write colliding with an `eng_done` pulse resolves. The bench shows these by comparing every output against its behavioural model during both directed and random traffic.

// File: rtl/swact_pkg.sv
package swact_pkg;

    localparam int unsigned DEF_VEC_W    = 7;
    localparam int unsigned DEF_ADDR_W   = 16;
    localparam logic [15:0] DEF_VEC_BASE = 16'h0400;

    // Engine status bundle sampled each cycle
    typedef struct packed {
        logic busy;
        logic done;
        logic cnt_zero;
        logic chain_sel;
    } eng_stat_t;

    // Outcome of an end-of-transfer event for the enable flag
    typedef enum logic [1:0] {
        HW_IDLE     = 2'd0,
        HW_AUTO_CLR = 2'd1,
        HW_HOLD     = 2'd2
    } hw_evt_e;

    // Decoded CPU write intent
    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic ld_vec;
    } cpu_cmd_t;

    function automatic hw_evt_e classify_end(input logic en, input eng_stat_t st);
        if (!en || !st.done) return HW_IDLE;
        if (st.cnt_zero || st.chain_sel) return HW_HOLD;
        return HW_AUTO_CLR;
    endfunction

endpackage

// File: rtl/swact_bus_dec.sv
module swact_bus_dec
    import swact_pkg::*;
#(
    parameter int unsigned VEC_W = DEF_VEC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               standby,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [VEC_W:0]     wdata,
    input  logic               en_q,
    input  logic               irq_q,
    input  logic               eng_busy,
    input  hw_evt_e            hw_evt,
    input  logic [VEC_W:0]     reg_val,
    output cpu_cmd_t           cmd,
    output logic [VEC_W:0]     rdata
);
    localparam int unsigned EN_BIT = VEC_W;

    logic wr_one;
    logic hw_owns;

    assign wr_one  = wdata[EN_BIT];
    assign hw_owns = (hw_evt != HW_IDLE);

    // Lock and set decisions use the flag value before this write
    always_comb begin
        cmd        = '0;
        cmd.ld_vec = wr_en && !en_q;
        cmd.set_en = wr_en && !en_q && wr_one;
        cmd.clr_en = wr_en && en_q && !wr_one && irq_q && !eng_busy && !hw_owns;
    end

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= reg_val;
        end
    end

endmodule

// File: rtl/swact_flag_ctl.sv
module swact_flag_ctl
    import swact_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      standby,
    input  cpu_cmd_t  cmd,
    input  eng_stat_t stat,
    output logic      en_q,
    output logic      irq_q,
    output logic      act_req,
    output hw_evt_e   hw_evt
);

    assign hw_evt = classify_end(en_q, stat);

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            en_q    <= 1'b0;
            irq_q   <= 1'b0;
            act_req <= 1'b0;
        end else begin
            act_req <= cmd.set_en;
            unique case (hw_evt)
                HW_AUTO_CLR: begin
                    en_q  <= 1'b0;
                    irq_q <= 1'b0;
                end
                HW_HOLD: begin
                    irq_q <= 1'b1;
                end
                default: begin
                    if (cmd.set_en) begin
                        en_q <= 1'b1;
                    end else if (cmd.clr_en) begin
                        en_q  <= 1'b0;
                        irq_q <= 1'b0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/swact_vec_store.sv
module swact_vec_store
    import swact_pkg::*;
#(
    parameter int unsigned           VEC_W    = DEF_VEC_W,
    parameter int unsigned           ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0]     VEC_BASE = ADDR_W'(DEF_VEC_BASE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              ld_vec,
    input  logic [VEC_W-1:0]  vec_in,
    output logic [VEC_W-1:0]  vec_q,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam int unsigned OFS_W = VEC_W + 1;

    logic [OFS_W-1:0] byte_ofs;

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            vec_q <= '0;
        end else if (ld_vec) begin
            vec_q <= vec_in;
        end
    end

    assign byte_ofs = {vec_q, 1'b0};
    assign vec_addr = VEC_BASE + ADDR_W'(byte_ofs);

endmodule

// File: rtl/swact_act_reg.sv
module swact_act_reg
    import swact_pkg::*;
#(
    parameter int unsigned       VEC_W    = DEF_VEC_W,
    parameter int unsigned       ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(DEF_VEC_BASE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_standby,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [VEC_W:0]    bus_wdata,
    output logic [VEC_W:0]    bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_cnt_zero,
    input  logic              eng_chain_sel,
    output logic              act_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              done_irq
);
    eng_stat_t        stat;
    cpu_cmd_t         cmd;
    hw_evt_e          hw_evt;
    logic             en_q;
    logic             irq_q;
    logic [VEC_W-1:0] vec_q;
    logic [VEC_W:0]   reg_val;

    assign stat     = '{busy: eng_busy, done: eng_done,
                        cnt_zero: eng_cnt_zero, chain_sel: eng_chain_sel};
    assign reg_val  = {en_q, vec_q};
    assign done_irq = irq_q;

    swact_bus_dec #(.VEC_W(VEC_W)) i_dec (
        .clk      (clk),
        .rst      (rst),
        .standby  (hw_standby),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .wdata    (bus_wdata),
        .en_q     (en_q),
        .irq_q    (irq_q),
        .eng_busy (eng_busy),
        .hw_evt   (hw_evt),
        .reg_val  (reg_val),
        .cmd      (cmd),
        .rdata    (bus_rdata)
    );

    swact_flag_ctl i_flag (
        .clk     (clk),
        .rst     (rst),
        .standby (hw_standby),
        .cmd     (cmd),
        .stat    (stat),
        .en_q    (en_q),
        .irq_q   (irq_q),
        .act_req (act_req),
        .hw_evt  (hw_evt)
    );

    swact_vec_store #(
        .VEC_W    (VEC_W),
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) i_vec (
        .clk      (clk),
        .rst      (rst),
        .standby  (hw_standby),
        .ld_vec   (cmd.ld_vec),
        .vec_in   (bus_wdata[VEC_W-1:0]),
        .vec_q    (vec_q),
        .vec_addr (vec_addr)
    );

endmodule

// File: rtl/swact_act_reg_chk.sv
module swact_act_reg_chk #(
    parameter int unsigned VEC_W  = 7,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              hw_standby,
    input logic              bus_wr,
    input logic [VEC_W:0]    bus_wdata,
    input logic              eng_busy,
    input logic              eng_done,
    input logic              eng_cnt_zero,
    input logic              eng_chain_sel,
    input logic              act_req,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              done_irq,
    input logic              en_q,
    input logic [VEC_W-1:0]  vec_q
);

    assert_standby_clear_R2: assert property (@(posedge clk) disable iff (rst)
        hw_standby |=> (!en_q && vec_q == '0 && !done_irq && !act_req));

    assert_vec_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (en_q && !hw_standby) |=> $stable(vec_q));

    assert_addr_even_R4: assert property (@(posedge clk) disable iff (rst)
        vec_addr[0] == 1'b0);

    assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
        act_req |=> !act_req);

    assert_req_with_flag_R5: assert property (@(posedge clk) disable iff (rst)
        act_req |-> en_q);

    assert_auto_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (en_q && eng_done && !eng_cnt_zero && !eng_chain_sel && !hw_standby)
        |=> (!en_q && !done_irq));

    assert_hold_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (en_q && eng_done && (eng_cnt_zero || eng_chain_sel) && !hw_standby)
        |=> (en_q && done_irq));

    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (en_q && !eng_done && !hw_standby &&
         (!bus_wr || bus_wdata[VEC_W] || !done_irq || eng_busy))
        |=> en_q);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> en_q);

    assert_idle_done_R11: assert property (@(posedge clk) disable iff (rst)
        (!en_q && eng_done && !(bus_wr && bus_wdata[VEC_W]) && !hw_standby)
        |=> (!en_q && !done_irq));

endmodule

bind swact_act_reg swact_act_reg_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .hw_standby    (hw_standby),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .eng_busy      (eng_busy),
    .eng_done      (eng_done),
    .eng_cnt_zero  (eng_cnt_zero),
    .eng_chain_sel (eng_chain_sel),
    .act_req       (act_req),
    .vec_addr      (vec_addr),
    .done_irq      (done_irq),
    .en_q          (en_q),
    .vec_q         (vec_q)
);

// File: tb/test_swact_act_reg.sv
module test_swact_act_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_standby = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_cnt_zero = 1'b0;
    logic        eng_chain_sel = 1'b0;
    logic        act_req;
    logic [15:0] vec_addr;
    logic        done_irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit cmp_on   = 1'b0;

    always #5 clk = ~clk;

    swact_act_reg i_swact_act_reg (
        .clk           (clk),
        .rst           (rst),
        .hw_standby    (hw_standby),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .eng_busy      (eng_busy),
        .eng_done      (eng_done),
        .eng_cnt_zero  (eng_cnt_zero),
        .eng_chain_sel (eng_chain_sel),
        .act_req       (act_req),
        .vec_addr      (vec_addr),
        .done_irq      (done_irq)
    );

    // Behavioural reference model
    bit       m_en  = 0;
    int       m_vec = 0;
    bit       m_irq = 0;
    bit       m_act = 0;
    int       m_rd  = 0;

    always @(posedge clk) begin
        bit pre_en;
        int pre_val;
        pre_en  = m_en;
        pre_val = (m_en ? 128 : 0) + m_vec;
        if (rst || hw_standby) begin
            m_en = 0; m_vec = 0; m_irq = 0; m_act = 0; m_rd = 0;
        end else begin
            m_act = 0;
            if (bus_rd) m_rd = pre_val;
            if (eng_done && pre_en) begin
                if (eng_cnt_zero || eng_chain_sel) m_irq = 1;
                else begin m_en = 0; m_irq = 0; end
            end else if (bus_wr) begin
                if (!pre_en) begin
                    m_vec = bus_wdata % 128;
                    if (bus_wdata >= 128) begin m_en = 1; m_act = 1; end
                end else if (bus_wdata < 128 && m_irq && !eng_busy) begin
                    m_en = 0; m_irq = 0;
                end
            end
        end
        cmp_on = 1'b1;
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output to the model each cycle
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk(16'(bus_rdata), 16'(m_rd), "R1 rdata vs model");
            chk(vec_addr, 16'(16'h0400 + 2 * m_vec), "R4 vec_addr vs model");
            chk(16'(act_req), 16'(m_act), "R5 act_req vs model");
            chk(16'(done_irq), 16'(m_irq), "R7 done_irq vs model");
        end
    end

    task automatic step(input bit wr, input logic [7:0] wd, input bit rd,
                        input bit dn, input bit cz, input bit ch, input bit bz,
                        input bit sb);
        bus_wr = wr; bus_wdata = wd; bus_rd = rd;
        eng_done = dn; eng_cnt_zero = cz; eng_chain_sel = ch;
        eng_busy = bz; hw_standby = sb;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; eng_done = 0; hw_standby = 0;
    endtask

    task automatic wr_reg(input logic [7:0] wd);
        step(1, wd, 0, 0, 0, 0, eng_busy, 0);
    endtask

    task automatic rd_reg(output logic [7:0] v);
        step(0, 8'h00, 1, 0, 0, 0, eng_busy, 0);
        v = bus_rdata;
    endtask

    task automatic done_pulse(input bit cz, input bit ch);
        step(0, 8'h00, 0, 1, cz, ch, eng_busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        rd_reg(v); chk(16'(v), 16'h00, "R2 reset value");
        chk(vec_addr, 16'h0400, "R4 reset address");
        chk(16'(done_irq), 16'h0, "R2 reset irq");

        // R3/R4 vector write while disabled
        wr_reg(8'h10);
        chk(vec_addr, 16'h0420, "R4 vector 0x10 address");
        chk(16'(act_req), 16'h0, "R5 no request without enable");
        rd_reg(v); chk(16'(v), 16'h10, "R1 readback 0x10");
        rd_reg(v); chk(16'(v), 16'h10, "R1 read has no side effect");

        // R5 set enable
        wr_reg(8'h85);
        chk(16'(act_req), 16'h1, "R5 request pulse");
        chk(vec_addr, 16'h040A, "R4 vector 5 address");
        @(negedge clk);
        chk(16'(act_req), 16'h0, "R5 request one cycle");
        rd_reg(v); chk(16'(v), 16'h85, "R5 flag set");

        // R3 locked vector
        wr_reg(8'hA2);
        rd_reg(v); chk(16'(v), 16'h85, "R3 vector locked");
        // R8 write 0 without interrupt ignored, busy holds
        wr_reg(8'h00);
        eng_busy = 1'b1;
        repeat (4) @(negedge clk);
        rd_reg(v); chk(16'(v), 16'h85, "R8 flag holds");
        eng_busy = 1'b0;

        // R6 auto clear
        done_pulse(0, 0);
        chk(16'(done_irq), 16'h0, "R6 no irq");
        rd_reg(v); chk(16'(v), 16'h05, "R6 auto clear");

        // R7 chain hold, R9 busy-blocked and real clear
        wr_reg(8'h83);
        done_pulse(0, 1);
        chk(16'(done_irq), 16'h1, "R7 irq on chain");
        rd_reg(v); chk(16'(v), 16'h83, "R7 flag held");
        eng_busy = 1'b1;
        wr_reg(8'h00);
        chk(16'(done_irq), 16'h1, "R9 busy blocks clear");
        eng_busy = 1'b0;
        wr_reg(8'h7F);
        chk(16'(done_irq), 16'h0, "R9 irq cleared");
        rd_reg(v); chk(16'(v), 16'h03, "R9 flag cleared vector kept");

        // R7 count exhausted
        wr_reg(8'h84);
        done_pulse(1, 0);
        chk(16'(done_irq), 16'h1, "R7 irq on count end");
        repeat (3) @(negedge clk);
        chk(16'(done_irq), 16'h1, "R7 irq persists");
        wr_reg(8'h00);
        rd_reg(v); chk(16'(v), 16'h04, "R9 clear after count end");

        // R10 collisions
        wr_reg(8'h86);
        step(1, 8'h99, 0, 1, 0, 0, 0, 0);
        rd_reg(v); chk(16'(v), 16'h06, "R10 auto clear wins, vector locked");
        wr_reg(8'h87);
        step(1, 8'h00, 0, 1, 0, 1, 0, 0);
        chk(16'(done_irq), 16'h1, "R10 hold wins over write");
        rd_reg(v); chk(16'(v), 16'h87, "R10 flag held");
        wr_reg(8'h00);

        // R11 done while disabled
        done_pulse(0, 1);
        chk(16'(done_irq), 16'h0, "R11 no irq when disabled");
        rd_reg(v); chk(16'(v), 16'h07, "R11 register unchanged");

        // R2 standby
        wr_reg(8'h92);
        done_pulse(1, 0);
        step(1, 8'h55, 0, 0, 0, 0, 0, 1);
        chk(16'(done_irq), 16'h0, "R2 standby irq");
        chk(vec_addr, 16'h0400, "R2 standby vector");
        rd_reg(v); chk(16'(v), 16'h00, "R2 standby value");

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 2) == 0,
                 $urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 60) == 0);
        end
        eng_busy = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule